// File: doc/BRIEF.md
# Serial NOR Flash Command and Status Engine

This block is the device-side command engine of a serial NOR flash. A front end outside the block deserializes the serial lines into bytes and hands each one over with a one-cycle strobe while chip-select is low. The first byte of every chip-select frame is an opcode. The engine decodes it, collects any address bytes, and answers each later byte slot through a response byte. Depending on the opcode, that response is the identification code, the status register or array data.

The engine holds the status register. This covers the write-enable latch, the status-write lock that works together with the hardware write-protect pin, the block-protect field and the 3-byte or 4-byte address mode. It does not hold the array. Reads, byte programs, sector erases and whole-array erases go out as requests on a plain storage port. Array data comes back combinationally on that same port. Busy periods are not modelled.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the status register reads 0x00 and the address mode is 3-byte. While no response is defined (chip-select high, or a slot with no answer), `tx_byte` is 0xFF.
- R2: Opcode 0x9F answers its following three slots with 0x20, 0xBA and 0x19, in that order, and answers 0x00 after those three.
- R3: Opcode 0x06 sets status bit 1 (the write-enable latch), and opcode 0x04 clears it. Opcode 0x05 answers every following slot of its frame with the status byte.
- R4: Opcode 0x01 writes its next byte into status bits 7..2, except when `wp_n` is low and status bit 7 is 1. In that case the status register stays unchanged.
- R5: Opcodes 0x02, 0xD8, 0xC7 and 0x01 act only when the write-enable latch is set. Otherwise they raise no storage request and change no status bit.
- R6: Opcode 0x03 followed by the address (most significant byte first) streams `mem_rdata` on the next slots, and the address grows by one per slot.
- R7: After opcode 0x02 and its address, each data byte raises `mem_prog` in the same cycle with that byte and its address. The low 8 address bits wrap within the 256-byte page.
- R8: Opcode 0xD8 with a complete address raises `mem_erase_sec` for one cycle in the first cycle that chip-select is high, with the address's low 16 bits cleared. An incomplete address raises nothing.
- R9: Opcode 0xC7 raises `mem_erase_all` for one cycle in the first cycle that chip-select is high.
- R10: At the end of a frame whose 0x02, 0xD8, 0xC7 or 0x01 opcode was accepted, the write-enable latch is cleared.
- R11: Opcode 0xB7 switches to 4-byte addressing, so later address phases take four bytes.
- R12: Opcode 0x99 returns the engine to 3-byte addressing and clears the write-enable latch, but only if the opcode of the frame just before it was 0x66. Otherwise 0x99 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip-select, low during a frame |
| rx_vld | input | 1 | Strobe: one received byte |
| rx_byte | input | 8 | Received byte |
| wp_n | input | 1 | Hardware write-protect, active low |
| tx_byte | output | 8 | Response for the next byte slot |
| mem_addr | output | AW (25) | Storage address |
| mem_rdata | input | 8 | Storage data at `mem_addr` (combinational) |
| mem_prog | output | 1 | Program strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Program data |
| mem_erase_sec | output | 1 | Sector erase strobe, address sector-aligned |
| mem_erase_all | output | 1 | Whole-array erase strobe |

## Verification
`tx_byte` for a slot is computed from the state left by the clock edge that consumed the previous byte. The bench therefore samples it 1 ns after it drives the slot's byte, and before the edge that consumes that byte. `mem_prog` comes in the same cycle as its data byte, and both erase strobes come in the first cycle with chip-select high. A bench monitor records them at that clock edge, and the checks compare the recorded lists once the frame has ended. A status change made by one frame is checked through a 0x05 read in a later frame.

// File: rtl/nor_cmd_pkg.sv
// Opcodes and state encodings shared by the NOR command engine.
// Assumes byte-framed traffic: the first byte of each chip-select frame is an opcode.
package nor_cmd_pkg;
    localparam logic [7:0] OP_RDID  = 8'h9F;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_SERA  = 8'hD8;
    localparam logic [7:0] OP_BERA  = 8'hC7;
    localparam logic [7:0] OP_WIDE  = 8'hB7;
    localparam logic [7:0] OP_RSTEN = 8'h66;
    localparam logic [7:0] OP_RSTGO = 8'h99;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_READ, ST_PROG, ST_ID, ST_STAT, ST_WRS, ST_SKIP
    } nor_state_e;

    typedef enum logic [1:0] {
        K_READ, K_PROG, K_SERASE
    } addr_kind_e;
endpackage

// File: rtl/nor_status_reg.sv
// Status register: write-enable latch, lockable protect bits, address mode.
// Assumes set/clear strobes are single-cycle; soft reset wins over all of them.
module nor_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel_set,
    input  logic       wel_clr,
    input  logic       sr_wr,
    input  logic [7:2] sr_wdata,
    input  logic       wp_n,
    input  logic       mode4_set,
    input  logic       soft_rst,
    output logic [7:0] status,
    output logic       addr4
);
    logic [5:0] keep_bits;
    logic       wel;
    logic       locked;

    // Status writes are refused when the pin and the lock bit both protect.
    assign locked = !wp_n && keep_bits[5];

    // Latch, mode and stored bits update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_bits <= '0;
            wel       <= 1'b0;
            addr4     <= 1'b0;
        end else begin
            if (soft_rst) begin
                wel   <= 1'b0;
                addr4 <= 1'b0;
            end else begin
                if (wel_set)      wel <= 1'b1;
                else if (wel_clr) wel <= 1'b0;
                if (mode4_set)    addr4 <= 1'b1;
            end
            if (sr_wr && !locked) keep_bits <= sr_wdata;
        end
    end

    assign status = {keep_bits, wel, 1'b0};

    a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && !wp_n && status[7]) |=> $stable(status[7:2]));
    a_r4_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && (wp_n || !status[7])) |=> (status[7:2] == $past(sr_wdata)));
    a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!addr4 && !status[1]));
    a_r3_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_set && !soft_rst) |=> status[1]);
endmodule

// File: rtl/nor_addr_seq.sv
// Address collector: shifts address bytes MSB first, then steps the address
// linearly (read stream) or within the page (program).
// Assumes AW > 8 and that a clear precedes each address phase.
module nor_addr_seq #(
    parameter int AW     = 25,
    parameter int PAGE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_clr,
    input  logic          shift_en,
    input  logic [7:0]    shift_byte,
    input  logic          addr4,
    input  logic          incr,
    input  logic          pincr,
    output logic [AW-1:0] addr,
    output logic          last_byte
);
    logic [AW-1:0] shreg;
    logic [2:0]    cnt;
    logic [2:0]    need_m1;

    assign need_m1   = addr4 ? 3'd3 : 3'd2;
    assign last_byte = shift_en && (cnt == need_m1);

    // Address assembly and stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (load_clr) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[AW-9:0], shift_byte};
            cnt   <= cnt + 3'd1;
        end else if (incr) begin
            shreg <= shreg + 1'b1;
        end else if (pincr) begin
            shreg[PAGE_W-1:0] <= shreg[PAGE_W-1:0] + 1'b1;
        end
    end

    assign addr = shreg;

    a_r11_addr_count: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> (cnt <= need_m1));
    a_r7_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        pincr |=> (addr[AW-1:PAGE_W] == $past(addr[AW-1:PAGE_W])));
endmodule

// File: rtl/nor_cmd_ctrl.sv
// Top of the NOR command engine: opcode decoder, response mux, storage requests.
// Assumes rx_vld is a one-cycle strobe per byte, and mem_rdata follows mem_addr
// combinationally. Erase strobes fire in the first cycle cs_n is seen high.
module nor_cmd_ctrl
    import nor_cmd_pkg::*;
#(
    parameter int          AW     = 25,
    parameter int          PAGE_W = 8,
    parameter int          SECT_W = 16,
    parameter logic [23:0] DEV_ID = 24'h20BA19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rx_vld,
    input  logic [7:0]    rx_byte,
    input  logic          wp_n,
    output logic [7:0]    tx_byte,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          mem_prog,
    output logic [7:0]    mem_wdata,
    output logic          mem_erase_sec,
    output logic          mem_erase_all
);
    nor_state_e    state;
    addr_kind_e    kind;
    logic [1:0]    id_idx;
    logic          cs_q, pend_se, pend_be, auto_clr, rst_arm;
    logic          byte_ev, frame_end, opc_ev, wel;
    logic          wel_set, wel_clr, sr_wr, mode4_set, soft_rst;
    logic          last_byte, addr4;
    logic [7:0]    status;
    logic [AW-1:0] cur_addr;

    assign byte_ev   = rx_vld && !cs_n;
    assign frame_end = !cs_q && cs_n;
    assign opc_ev    = byte_ev && (state == ST_IDLE);
    assign wel       = status[1];

    // Strobes toward the status register.
    assign wel_set   = opc_ev && (rx_byte == OP_WREN);
    assign wel_clr   = (opc_ev && (rx_byte == OP_WRDI)) || (frame_end && auto_clr);
    assign mode4_set = opc_ev && (rx_byte == OP_WIDE);
    assign soft_rst  = opc_ev && (rx_byte == OP_RSTGO) && rst_arm;
    assign sr_wr     = byte_ev && (state == ST_WRS);

    nor_status_reg u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr),
        .sr_wr     (sr_wr),
        .sr_wdata  (rx_byte[7:2]),
        .wp_n      (wp_n),
        .mode4_set (mode4_set),
        .soft_rst  (soft_rst),
        .status    (status),
        .addr4     (addr4)
    );

    nor_addr_seq #(.AW(AW), .PAGE_W(PAGE_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_clr   (opc_ev),
        .shift_en   (byte_ev && (state == ST_ADDR)),
        .shift_byte (rx_byte),
        .addr4      (addr4),
        .incr       (byte_ev && (state == ST_READ)),
        .pincr      (byte_ev && (state == ST_PROG)),
        .addr       (cur_addr),
        .last_byte  (last_byte)
    );

    // Frame sequencer: opcode decode, phase tracking, pending erases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= K_READ;
            id_idx   <= '0;
            cs_q     <= 1'b1;
            pend_se  <= 1'b0;
            pend_be  <= 1'b0;
            auto_clr <= 1'b0;
            rst_arm  <= 1'b0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                state    <= ST_IDLE;
                pend_se  <= 1'b0;
                pend_be  <= 1'b0;
                auto_clr <= 1'b0;
            end else if (byte_ev) begin
                case (state)
                    ST_IDLE: begin
                        rst_arm <= (rx_byte == OP_RSTEN);
                        state   <= ST_SKIP;
                        case (rx_byte)
                            OP_RDID: begin state <= ST_ID; id_idx <= '0; end
                            OP_RDSR: state <= ST_STAT;
                            OP_READ: begin state <= ST_ADDR; kind <= K_READ; end
                            OP_WRSR: if (wel) begin state <= ST_WRS; auto_clr <= 1'b1; end
                            OP_PROG: if (wel) begin
                                state <= ST_ADDR; kind <= K_PROG; auto_clr <= 1'b1;
                            end
                            OP_SERA: if (wel) begin
                                state <= ST_ADDR; kind <= K_SERASE; auto_clr <= 1'b1;
                            end
                            OP_BERA: if (wel) begin pend_be <= 1'b1; auto_clr <= 1'b1; end
                            default: ;
                        endcase
                    end
                    ST_ADDR: if (last_byte) begin
                        case (kind)
                            K_READ:  state <= ST_READ;
                            K_PROG:  state <= ST_PROG;
                            default: begin state <= ST_SKIP; pend_se <= 1'b1; end
                        endcase
                    end
                    ST_ID:   if (id_idx != 2'd3) id_idx <= id_idx + 2'd1;
                    ST_WRS:  state <= ST_SKIP;
                    default: ;
                endcase
            end
        end
    end

    // Response byte for the next slot.
    always_comb begin
        tx_byte = 8'hFF;
        case (state)
            ST_ID: begin
                case (id_idx)
                    2'd0:    tx_byte = DEV_ID[23:16];
                    2'd1:    tx_byte = DEV_ID[15:8];
                    2'd2:    tx_byte = DEV_ID[7:0];
                    default: tx_byte = 8'h00;
                endcase
            end
            ST_STAT: tx_byte = status;
            ST_READ: tx_byte = mem_rdata;
            default: tx_byte = 8'hFF;
        endcase
    end

    // Storage port requests.
    assign mem_prog      = byte_ev && (state == ST_PROG);
    assign mem_wdata     = rx_byte;
    assign mem_erase_sec = frame_end && pend_se;
    assign mem_erase_all = frame_end && pend_be;
    assign mem_addr      = mem_erase_sec ? {cur_addr[AW-1:SECT_W], {SECT_W{1'b0}}} : cur_addr;

    a_r5_prog_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        mem_prog |-> wel);
    a_r5_erase_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_erase_sec || mem_erase_all) |-> wel);
    a_r10_wel_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        mem_erase_all |=> !wel);
    a_r1_idle_response: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (tx_byte == 8'hFF));
    a_r8_single_erase: assert property (@(posedge clk) disable iff (!rst_n)
        mem_erase_sec |=> !mem_erase_sec);
endmodule

// File: tb/nor_cmd_ctrl_tb.sv
module nor_cmd_ctrl_tb;
    localparam int AW = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          rx_vld = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          wp_n = 1'b1;
    logic [7:0]    tx_byte;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic          mem_prog, mem_erase_sec, mem_erase_all;
    logic [7:0]    mem_wdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [AW-1:0] prog_a_q[$];
    logic [7:0]    prog_d_q[$];
    int            se_cnt = 0;
    int            be_cnt = 0;
    logic [AW-1:0] se_addr = '0;

    always #4 clk = ~clk;

    nor_cmd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .wp_n(wp_n), .tx_byte(tx_byte), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_prog(mem_prog), .mem_wdata(mem_wdata),
        .mem_erase_sec(mem_erase_sec), .mem_erase_all(mem_erase_all)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ {7'd0, a[24]} ^ 8'h5A;
    endfunction

    always_comb mem_rdata = pat(mem_addr);

    // Record storage requests at the consuming edge.
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_prog) begin prog_a_q.push_back(mem_addr); prog_d_q.push_back(mem_wdata); end
            if (mem_erase_sec) begin se_cnt++; se_addr = mem_addr; end
            if (mem_erase_all) be_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        @(negedge clk);
        cs_n = 1'b0; rx_vld = 1'b1; rx_byte = b;
        #1 r = tx_byte;
        @(posedge clk);
        #1 rx_vld = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        xfer(b, r);
    endtask

    task automatic cs_hi();
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        send(op); cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] s);
        send(8'h05); xfer(8'h00, s); cs_hi();
    endtask

    task automatic send_addr(input logic [31:0] a, input bit four);
        if (four) send(a[31:24]);
        send(a[23:16]); send(a[15:8]); send(a[7:0]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0]  r, s;
        logic [31:0] a;
        int          n, base;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and idle response.
        chk("R1 idle tx", {24'd0, tx_byte}, 32'hFF);
        rdsr(s);
        chk("R1 status after reset", {24'd0, s}, 32'h00);

        // R2: identification bytes.
        send(8'h9F);
        xfer(8'h00, r); chk("R2 id0", {24'd0, r}, 32'h20);
        xfer(8'h00, r); chk("R2 id1", {24'd0, r}, 32'hBA);
        xfer(8'h00, r); chk("R2 id2", {24'd0, r}, 32'h19);
        xfer(8'h00, r); chk("R2 id after", {24'd0, r}, 32'h00);
        cs_hi();

        // R3: latch set and clear, repeated status slots.
        cmd1(8'h06);
        send(8'h05); xfer(8'h00, s); xfer(8'h00, r); cs_hi();
        chk("R3 wel set", {24'd0, s}, 32'h02);
        chk("R3 status repeats", {24'd0, r}, 32'h02);
        cmd1(8'h04); rdsr(s);
        chk("R3 wel clear", {24'd0, s}, 32'h00);

        // R5: status write without latch is ignored.
        send(8'h01); send(8'hFC); cs_hi(); rdsr(s);
        chk("R5 wrsr without wel", {24'd0, s}, 32'h00);

        // R4 and R10: protect interplay, latch cleared at frame end.
        cmd1(8'h06); send(8'h01); send(8'h80); cs_hi(); rdsr(s);
        chk("R4 wp high lock write", {24'd0, s}, 32'h80);
        chk("R10 wel cleared after wrsr", {31'd0, s[1]}, 32'd0);
        cmd1(8'h06); send(8'h01); send(8'h00); cs_hi(); rdsr(s);
        chk("R4 wp high unlock", {24'd0, s}, 32'h00);
        wp_n = 1'b0;
        cmd1(8'h06); send(8'h01); send(8'h84); cs_hi(); rdsr(s);
        chk("R4 wp low lock clear", {24'd0, s}, 32'h84);
        cmd1(8'h06); send(8'h01); send(8'h00); cs_hi(); rdsr(s);
        chk("R4 wp low refused", {24'd0, s}, 32'h84);
        wp_n = 1'b1;
        cmd1(8'h06); send(8'h01); send(8'h00); cs_hi(); rdsr(s);
        chk("R4 released", {24'd0, s}, 32'h00);

        // R5: program and erases without latch raise nothing.
        prog_a_q.delete(); prog_d_q.delete();
        send(8'h02); send_addr(32'h001234, 1'b0); send(8'hAA); cs_hi();
        send(8'hD8); send_addr(32'h010000, 1'b0); cs_hi();
        cmd1(8'hC7);
        chk("R5 no prog", prog_a_q.size(), 0);
        chk("R5 no erase", se_cnt + be_cnt, 0);

        // R6, R7, R8: random reads, programs and erases in 3-byte mode.
        for (int it = 0; it < 24; it++) begin
            a = $urandom() & 32'h00FFFFFF;
            n = 2 + ($urandom() % 6);
            case ($urandom() % 3)
                0: begin
                    send(8'h03); send_addr(a, 1'b0);
                    for (int k = 0; k < n; k++) begin
                        xfer(8'h00, r);
                        chk("R6 read stream", {24'd0, r}, {24'd0, pat(AW'(a + k))});
                    end
                    cs_hi();
                end
                1: begin
                    a[7:0] = 8'hFE - 8'(n / 2);
                    prog_a_q.delete(); prog_d_q.delete();
                    cmd1(8'h06); send(8'h02); send_addr(a, 1'b0);
                    for (int k = 0; k < n; k++) send(8'(k * 37 + it));
                    cs_hi();
                    chk("R7 prog count", prog_a_q.size(), n);
                    for (int k = 0; k < n && k < prog_a_q.size(); k++) begin
                        chk("R7 prog addr", {7'd0, prog_a_q[k]},
                            {7'd0, a[24:8], 8'(a[7:0] + k)});
                        chk("R7 prog data", {24'd0, prog_d_q[k]}, {24'd0, 8'(k * 37 + it)});
                    end
                    rdsr(s);
                    chk("R10 wel after prog", {31'd0, s[1]}, 32'd0);
                end
                default: begin
                    base = se_cnt;
                    cmd1(8'h06); send(8'hD8); send_addr(a, 1'b0); cs_hi();
                    chk("R8 erase count", se_cnt - base, 1);
                    chk("R8 erase addr", {7'd0, se_addr}, {7'd0, a[24:16], 16'd0});
                end
            endcase
        end

        // R8: incomplete address gives no erase.
        base = se_cnt;
        cmd1(8'h06); send(8'hD8); send(8'h12); send(8'h34); cs_hi();
        chk("R8 short address", se_cnt - base, 0);

        // R9 and R10: whole-array erase.
        cmd1(8'h06); cmd1(8'hC7); rdsr(s);
        chk("R9 bulk erase", be_cnt, 1);
        chk("R10 wel after bulk", {31'd0, s[1]}, 32'd0);

        // R11: 4-byte addressing.
        cmd1(8'hB7);
        send(8'h03); send_addr(32'h01ABCDEF, 1'b1); xfer(8'h00, r); cs_hi();
        chk("R11 wide read", {24'd0, r}, {24'd0, pat(25'h1ABCDEF)});

        // R12: lone reset opcode has no effect.
        cmd1(8'h99);
        send(8'h03); send_addr(32'h01000010, 1'b1); xfer(8'h00, r); cs_hi();
        chk("R12 lone 99 ignored", {24'd0, r}, {24'd0, pat(25'h1000010)});

        // R12: armed reset returns to 3-byte mode and clears latch.
        cmd1(8'h06); cmd1(8'h66); cmd1(8'h99); rdsr(s);
        chk("R12 wel cleared", {31'd0, s[1]}, 32'd0);
        send(8'h03); send_addr(32'h00123456, 1'b0); xfer(8'h00, r); cs_hi();
        chk("R12 narrow mode", {24'd0, r}, {24'd0, pat(25'h0123456)});
        chk("R1 idle tx end", {24'd0, tx_byte}, 32'hFF);

        finish_run();
    end
endmodule